// File: doc/BRIEF.md
# Motor Lock and Supply Fault Supervisor

This block decides whether the external bridge transistors of a three-phase motor drive may conduct. It follows a start/stop level, where high requests stop and is the level an unconnected pin settles to. It also watches three things: the phase-lock flag of the speed loop, an undervoltage comparator output and a thermal flag. Whenever it is in start and the loop stays out of lock for a programmable number of slow timebase ticks, it raises a lock fault and turns the bridge off. That fault stays latched until stop is requested again or reset is applied.

A strobe marks each change of the speed reference rate. The strobe restarts the lock timer, so the slowdown that follows a rate switch cannot trip the fault. A strap input removes the lock timer completely. The block also produces a soft-start duty ceiling for the supply-modulation drive mode. The ceiling climbs from zero to full scale as ticks arrive after startup and drops back to zero in stop. In direct-PWM mode the ceiling output sits at full scale.

Top module: `mfs_supervisor`

## Requirements
- R1: Reset gives bridge_en = 0, lock_fault = 0 and a ramp value of 0. While stop_req is 1, bridge_en is 0 from the next clock edge on.
- R2: In start (stop_req = 0) with the timer enabled and lock_ok = 0, lock_fault goes to 1 on the edge of the N-th tick counted since the last restart, where N is trip_ticks, or 1 when trip_ticks is 0. bridge_en falls on that same edge, and bridge_en is never 1 while lock_fault is 1.
- R3: Once set, lock_fault stays at 1 even after lock_ok returns. Only stop_req = 1 or reset clears it, and it is 0 one edge after stop_req is sampled high.
- R4: The lock timer restarts whenever lock_ok is 1 and whenever the block passes through stop.
- R5: A cycle with ref_chg = 1 restarts the lock timer. A tick that arrives in the same cycle as ref_chg is neither counted nor able to trip the fault.
- R6: With tmr_en = 0 the lock fault never sets, however many ticks arrive out of lock.
- R7: uv_trip = 1 forces bridge_en to 0 from the next edge, and bridge_en comes back one edge after uv_trip returns to 0. The undervoltage path leaves lock_fault unchanged.
- R8: hot_flag = 1 forces bridge_en to 0 from the next edge, and bridge_en recovers one edge after hot_flag clears.
- R9: In start the ramp rises by RAMP_STEP on each tick edge and saturates at 2^DUTY_W-1. It is 0 one edge after stop_req is sampled high.
- R10: ss_duty equals the ramp when supply_mod = 1 and equals 2^DUTY_W-1 when supply_mod = 0. It follows supply_mod within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| stop_req | input | 1 | 1 = stop, 0 = start |
| lock_ok | input | 1 | Speed loop phase lock flag |
| tick | input | 1 | One-cycle slow timebase pulse |
| tmr_en | input | 1 | Lock timer enable strap |
| uv_trip | input | 1 | Undervoltage comparator output (hysteresis is external) |
| hot_flag | input | 1 | Thermal shutdown flag |
| ref_chg | input | 1 | Reference rate change strobe |
| supply_mod | input | 1 | 1 = supply-modulation mode, 0 = direct PWM |
| trip_ticks | input | TRIP_W | Lock trigger interval in ticks |
| bridge_en | output | 1 | Bridge drive enable |
| lock_fault | output | 1 | Latched lock fault |
| ss_duty | output | DUTY_W | Soft-start duty ceiling |

## Verification
bridge_en, lock_fault and the ramp are registers, so each of them answers a stimulus one rising edge later. ss_duty follows supply_mod with no edge between them. The bench drives every input just after a falling edge. It compares registered results at the next falling edge, which is one rising edge later. It checks the combinational mode select one time unit after driving it. The trip interval is swept over 0 to 5 ticks, and the ramp is swept through every value up to saturation. Both sweeps give the tick at which the fault or each duty value must appear, and the bench samples at that tick.

// File: rtl/mfs_pkg.sv
package mfs_pkg;
   typedef struct packed {
      logic run;
      logic uv;
      logic hot;
   } mfs_gate_t;

   function automatic logic gate_ok(mfs_gate_t g, logic fault);
      return g.run && !g.uv && !g.hot && !fault;
   endfunction
endpackage

// File: rtl/mfs_lock_timer.sv
module mfs_lock_timer #(
   parameter int TRIP_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              tmr_en,
   input  logic              lock_ok,
   input  logic              ref_chg,
   input  logic              tick,
   input  logic [TRIP_W-1:0] trip_ticks,
   output logic              fault_nxt,
   output logic              fault_q
);
   localparam int CW = TRIP_W + 1;

   logic [TRIP_W-1:0] cnt_q;
   logic [CW-1:0]     cnt_inc;
   logic              restart;
   logic              expire;

   assign cnt_inc   = {1'b0, cnt_q} + CW'(1);
   assign restart   = !run || !tmr_en || lock_ok || ref_chg;
   assign expire    = !restart && tick && (cnt_inc >= {1'b0, trip_ticks});
   assign fault_nxt = run && (fault_q || expire);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         fault_q <= 1'b0;
      end else begin
         fault_q <= fault_nxt;
         if (restart)
            cnt_q <= '0;
         else if (tick && (cnt_q != {TRIP_W{1'b1}}))
            cnt_q <= cnt_inc[TRIP_W-1:0];
      end
   end
endmodule

// File: rtl/mfs_soft_ramp.sv
module mfs_soft_ramp #(
   parameter int DUTY_W    = 8,
   parameter int RAMP_STEP = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              tick,
   output logic [DUTY_W-1:0] ramp
);
   localparam logic [DUTY_W-1:0] FULL = {DUTY_W{1'b1}};

   logic [DUTY_W-1:0] ramp_nxt;

   generate
      if (RAMP_STEP == 1) begin : g_unit
         assign ramp_nxt = (ramp == FULL) ? FULL : ramp + DUTY_W'(1);
      end else begin : g_wide
         logic [DUTY_W:0] sum;
         assign sum      = {1'b0, ramp} + (DUTY_W+1)'(RAMP_STEP);
         assign ramp_nxt = (sum > {1'b0, FULL}) ? FULL : sum[DUTY_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ramp <= '0;
      else if (!run)
         ramp <= '0;
      else if (tick)
         ramp <= ramp_nxt;
   end
endmodule

// File: rtl/mfs_supervisor.sv
module mfs_supervisor #(
   parameter int TRIP_W    = 8,
   parameter int DUTY_W    = 8,
   parameter int RAMP_STEP = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stop_req,
   input  logic              lock_ok,
   input  logic              tick,
   input  logic              tmr_en,
   input  logic              uv_trip,
   input  logic              hot_flag,
   input  logic              ref_chg,
   input  logic              supply_mod,
   input  logic [TRIP_W-1:0] trip_ticks,
   output logic              bridge_en,
   output logic              lock_fault,
   output logic [DUTY_W-1:0] ss_duty
);
   import mfs_pkg::*;

   localparam logic [DUTY_W-1:0] FULL = {DUTY_W{1'b1}};

   if (TRIP_W < 2) begin : g_bad_trip
      $error("TRIP_W must be at least 2");
   end
   if (DUTY_W < 2) begin : g_bad_duty
      $error("DUTY_W must be at least 2");
   end
   if (RAMP_STEP < 1 || RAMP_STEP > (1 << DUTY_W) - 1) begin : g_bad_step
      $error("RAMP_STEP out of range");
   end

   mfs_gate_t         gate;
   logic              fault_nxt;
   logic [DUTY_W-1:0] ramp_q;

   assign gate.run = !stop_req;
   assign gate.uv  = uv_trip;
   assign gate.hot = hot_flag;

   mfs_lock_timer #(.TRIP_W(TRIP_W)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (gate.run),
      .tmr_en     (tmr_en),
      .lock_ok    (lock_ok),
      .ref_chg    (ref_chg),
      .tick       (tick),
      .trip_ticks (trip_ticks),
      .fault_nxt  (fault_nxt),
      .fault_q    (lock_fault)
   );

   mfs_soft_ramp #(.DUTY_W(DUTY_W), .RAMP_STEP(RAMP_STEP)) u_ramp (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (gate.run),
      .tick  (tick),
      .ramp  (ramp_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bridge_en <= 1'b0;
      else
         bridge_en <= gate_ok(gate, fault_nxt);
   end

   assign ss_duty = supply_mod ? ramp_q : FULL;
endmodule

// File: rtl/mfs_supervisor_chk.sv
module mfs_supervisor_chk #(
   parameter int DUTY_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              stop_req,
   input logic              tmr_en,
   input logic              uv_trip,
   input logic              hot_flag,
   input logic              ref_chg,
   input logic              bridge_en,
   input logic              lock_fault,
   input logic [DUTY_W-1:0] ramp
);
   a_r1_stop_off: assert property (@(posedge clk) disable iff (!rst_n)
      stop_req |=> !bridge_en);
   a_r2_fault_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      lock_fault |-> !bridge_en);
   a_r3_fault_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_fault && !stop_req) |=> lock_fault);
   a_r3_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
      stop_req |=> !lock_fault);
   a_r5_refchg_no_trip: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_chg && !lock_fault) |=> !lock_fault);
   a_r6_disabled_no_trip: assert property (@(posedge clk) disable iff (!rst_n)
      (!tmr_en && !lock_fault) |=> !lock_fault);
   a_r7_uv_off: assert property (@(posedge clk) disable iff (!rst_n)
      uv_trip |=> !bridge_en);
   a_r8_hot_off: assert property (@(posedge clk) disable iff (!rst_n)
      hot_flag |=> !bridge_en);
   a_r9_stop_ramp_zero: assert property (@(posedge clk) disable iff (!rst_n)
      stop_req |=> (ramp == '0));
endmodule

bind mfs_supervisor mfs_supervisor_chk #(.DUTY_W(DUTY_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .stop_req   (stop_req),
   .tmr_en     (tmr_en),
   .uv_trip    (uv_trip),
   .hot_flag   (hot_flag),
   .ref_chg    (ref_chg),
   .bridge_en  (bridge_en),
   .lock_fault (lock_fault),
   .ramp       (ramp_q)
);

// File: tb/test_mfs_supervisor.sv
`timescale 1ns/1ps
module test_mfs_supervisor;
   localparam int TW = 4;
   localparam int DW = 4;
   localparam int FULLV = (1 << DW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic stop_req = 1'b1, lock_ok = 1'b0, tick = 1'b0, tmr_en = 1'b1;
   logic uv_trip = 1'b0, hot_flag = 1'b0, ref_chg = 1'b0, supply_mod = 1'b1;
   logic [TW-1:0] trip_ticks = '0;
   logic          bridge_en, lock_fault;
   logic [DW-1:0] ss_duty;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   mfs_supervisor #(.TRIP_W(TW), .DUTY_W(DW), .RAMP_STEP(1)) i_mfs_supervisor (
      .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .lock_ok(lock_ok),
      .tick(tick), .tmr_en(tmr_en), .uv_trip(uv_trip), .hot_flag(hot_flag),
      .ref_chg(ref_chg), .supply_mod(supply_mod), .trip_ticks(trip_ticks),
      .bridge_en(bridge_en), .lock_fault(lock_fault), .ss_duty(ss_duty)
   );

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) begin
         tick = 1'b1; cyc();
         tick = 1'b0; cyc();
      end
   endtask

   task automatic go_start();
      stop_req = 1'b1; cyc();
      stop_req = 1'b0; cyc();
   endtask

   initial begin
      repeat (3) cyc();
      check("R1 reset bridge", int'(bridge_en), 0);
      check("R1 reset fault", int'(lock_fault), 0);
      check("R1 reset ramp", int'(ss_duty), 0);
      rst_n = 1'b1;
      cyc();
      check("R1 stop keeps bridge off", int'(bridge_en), 0);

      // R2 / R3 sweep of trip interval
      for (int n = 0; n <= 5; n++) begin
         int eff;
         eff = (n == 0) ? 1 : n;
         trip_ticks = TW'(n);
         go_start();
         check("R1 start enables bridge", int'(bridge_en), 1);
         ticks(eff - 1);
         check("R2 no fault before interval", int'(lock_fault), 0);
         check("R2 bridge on before interval", int'(bridge_en), 1);
         ticks(1);
         check("R2 fault at interval", int'(lock_fault), 1);
         check("R2 bridge off on fault", int'(bridge_en), 0);
         lock_ok = 1'b1;
         ticks(3);
         check("R3 fault latched after lock", int'(lock_fault), 1);
         check("R3 bridge stays off", int'(bridge_en), 0);
         lock_ok = 1'b0;
         stop_req = 1'b1; cyc();
         check("R3 stop clears fault", int'(lock_fault), 0);
         check("R1 stop bridge off", int'(bridge_en), 0);
      end

      // R4 lock restarts timer
      trip_ticks = TW'(4);
      go_start();
      ticks(3);
      lock_ok = 1'b1; cyc(); lock_ok = 1'b0; cyc();
      ticks(3);
      check("R4 lock restarts timer", int'(lock_fault), 0);
      ticks(1);
      check("R4 trip after restart", int'(lock_fault), 1);

      // R4 pass through stop restarts timer
      go_start();
      ticks(3);
      stop_req = 1'b1; cyc(); stop_req = 1'b0; cyc();
      ticks(3);
      check("R4 stop restarts timer", int'(lock_fault), 0);

      // R5 ref change restarts timer and masks coincident tick
      go_start();
      ticks(3);
      ref_chg = 1'b1; cyc(); ref_chg = 1'b0; cyc();
      ticks(3);
      check("R5 ref change restarts timer", int'(lock_fault), 0);
      ref_chg = 1'b1; tick = 1'b1; cyc();
      ref_chg = 1'b0; tick = 1'b0; cyc();
      check("R5 coincident tick ignored", int'(lock_fault), 0);
      check("R5 bridge still on", int'(bridge_en), 1);
      ticks(3);
      check("R5 count restarted", int'(lock_fault), 0);
      ticks(1);
      check("R5 trips after full interval", int'(lock_fault), 1);

      // R6 timer disabled
      tmr_en = 1'b0;
      trip_ticks = TW'(1);
      go_start();
      ticks(20);
      check("R6 disabled no fault", int'(lock_fault), 0);
      check("R6 bridge on", int'(bridge_en), 1);

      // R7 undervoltage
      uv_trip = 1'b1; cyc();
      check("R7 uv bridge off", int'(bridge_en), 0);
      check("R7 uv fault untouched", int'(lock_fault), 0);
      uv_trip = 1'b0; cyc();
      check("R7 uv release", int'(bridge_en), 1);

      // R8 thermal
      hot_flag = 1'b1; cyc();
      check("R8 hot bridge off", int'(bridge_en), 0);
      hot_flag = 1'b0; cyc();
      check("R8 hot release", int'(bridge_en), 1);

      // R9 / R10 ramp sweep
      supply_mod = 1'b1;
      go_start();
      for (int k = 0; k <= FULLV + 2; k++) begin
         check("R9 ramp value", int'(ss_duty), (k > FULLV) ? FULLV : k);
         if (k == 5) begin
            supply_mod = 1'b0; #1;
            check("R10 direct mode full scale", int'(ss_duty), FULLV);
            supply_mod = 1'b1; #1;
            check("R10 back to ramp", int'(ss_duty), 5);
            cyc();
         end
         ticks(1);
      end
      stop_req = 1'b1; cyc();
      check("R9 stop zeroes ramp", int'(ss_duty), 0);
      supply_mod = 1'b0; #1;
      check("R10 full scale in stop", int'(ss_duty), FULLV);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule